// File: doc/BRIEF.md
# USB OTG Attach-Detection Probe Timer

This block runs the timing for attach detection on a USB On-The-Go port. It is driven by a 32 kHz tick. In probe mode it repeats a fixed cycle. First it strobes a discharge output for a programmable number of ticks. Then it strobes a charge output and counts the ramp time, in prescaled units, until the probe-threshold comparator fires. It stores that count in an 11-bit ramp-time register and then idles until the selected probe period has passed. If the counter reaches its top code before the comparator fires, the block records a timeout instead.

In sense mode the block only watches the sense-threshold comparator. Probe, sense and timeout events each set a sticky flag. Software clears a flag by writing one to it. Each flag has its own unmask bit, and the unmasked flags are ORed into one interrupt output. The analog comparators and the register bus sit outside this block.

Top module: `adp_probe_timer`

## Requirements
- R1: After reset, dischargeOut, chargeOut, rampTime, all three flags and irq are 0.
- R2: When enable is 0 or ctrlReset is 1, the controller is idle from the next clock edge on: dischargeOut and chargeOut are 0, and the comparator inputs set no flag.
- R3: With enable=1, probeEn=1 selects probe mode and senseEn=1 alone selects sense mode. If both are set, probe mode wins and no sense flag is raised.
- R4: Each probe cycle starts with dischargeOut high for 128 << dischargeSel ticks (00=128, 01=256, 10=512, 11=1024). chargeOut then rises right away, and the two strobes are never high together. Cycles with tick low do not count.
- R5: During charge, the ramp counter starts at 0 and increments once every resolSel+1 ticks. When vbusAboveProbe is seen, rampTime captures the count of whole units elapsed, probeFlag sets, and chargeOut falls.
- R6: If the counter is at 0x7FF when another increment is due, after 2048*(resolSel+1) charge ticks, rampTime becomes 0x7FF, timeoutFlag sets, and chargeOut falls.
- R7: A new probe cycle starts every 24800 ticks for periodSel 00 and 11, every 49600 for 01, and every 72800 for 10.
- R8: probeFlag is set only by vbusAboveProbe during the charge phase. senseFlag is set only by vbusAboveSense in sense mode.
- R9: Flags are sticky. A one on clearProbe, clearSense or clearTimeout clears the matching flag. If a set and a clear occur in the same cycle, the flag stays set.
- R10: irq is high exactly when some flag is set while its mask input (probeMask, senseMask or timeoutMask) is 1.
- R11: rampTime changes only at a capture (R5 or R6) and holds its value between captures, in idle and while waiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle 32 kHz timing pulse |
| enable | input | 1 | Master enable |
| probeEn | input | 1 | Select probe mode |
| senseEn | input | 1 | Select sense mode |
| ctrlReset | input | 1 | Forces the controller to idle |
| dischargeSel | input | 2 | Discharge length select |
| resolSel | input | 2 | Ticks per ramp unit, minus one |
| periodSel | input | 2 | Probe repeat period select |
| vbusAboveProbe | input | 1 | Comparator: VBUS at probe threshold |
| vbusAboveSense | input | 1 | Comparator: VBUS at sense threshold |
| probeMask | input | 1 | Unmask probe flag onto irq |
| senseMask | input | 1 | Unmask sense flag onto irq |
| timeoutMask | input | 1 | Unmask timeout flag onto irq |
| clearProbe | input | 1 | Write-one clear of probe flag |
| clearSense | input | 1 | Write-one clear of sense flag |
| clearTimeout | input | 1 | Write-one clear of timeout flag |
| dischargeOut | output | 1 | Discharge strobe |
| chargeOut | output | 1 | Charge strobe |
| rampTime | output | 11 | Last captured ramp time |
| probeFlag | output | 1 | Sticky probe event flag |
| senseFlag | output | 1 | Sticky sense event flag |
| timeoutFlag | output | 1 | Sticky ramp timeout flag |
| irq | output | 1 | Combined unmasked interrupt |

## Verification
The hardest cases to reach are the period boundaries. The saturating timeout needs thousands of ticks of charge with the comparator held low, and the period check needs a full repeat interval between two discharge starts. The bench holds tick high on every clock so that ticks equal cycles. It then counts strobe-high cycles and the gap between discharge rises directly. One case gates tick to every other clock to show that idle cycles are not counted. The ramp capture is reached by releasing the comparator a known number of cycles after the charge strobe rises.

// File: rtl/adp_probe_pkg.sv
package adp_probe_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DISCH,
    ST_CHARGE,
    ST_WAIT,
    ST_SENSE
  } adpState_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic clrPeriod;
    logic clrPhase;
    logic clrRamp;
    logic capture;
    logic setProbe;
    logic setSense;
    logic setTimeout;
  } adpStrobe_t;

  // Status from datapath to control
  typedef struct packed {
    logic periodDone;
    logic dischDone;
    logic rampSat;
  } adpStatus_t;

endpackage

// File: rtl/adp_probe_ctrl.sv
module adp_probe_ctrl
  import adp_probe_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic       probeEn,
  input  logic       senseEn,
  input  logic       ctrlReset,
  input  logic       vbusAboveProbe,
  input  logic       vbusAboveSense,
  input  adpStatus_t status,
  output adpStrobe_t strobe,
  output logic       dischargeOut,
  output logic       chargeOut
);

  adpState_e state, nextState;
  logic      active;

  assign active = enable && !ctrlReset;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    strobe    = '0;
    if (!active) begin
      nextState        = ST_IDLE;
      strobe.clrPeriod = 1'b1;
      strobe.clrPhase  = 1'b1;
      strobe.clrRamp   = 1'b1;
    end else begin
      unique case (state)
        ST_IDLE: begin
          strobe.clrPeriod = 1'b1;
          strobe.clrPhase  = 1'b1;
          strobe.clrRamp   = 1'b1;
          if (probeEn)      nextState = ST_DISCH;
          else if (senseEn) nextState = ST_SENSE;
        end
        ST_DISCH: begin
          strobe.clrRamp = 1'b1;
          if (!probeEn) begin
            nextState        = ST_IDLE;
            strobe.clrPeriod = 1'b1;
            strobe.clrPhase  = 1'b1;
          end else if (status.periodDone) begin
            strobe.clrPeriod = 1'b1;
            strobe.clrPhase  = 1'b1;
          end else if (status.dischDone) begin
            strobe.clrPhase = 1'b1;
            nextState       = ST_CHARGE;
          end
        end
        ST_CHARGE: begin
          strobe.clrPhase = 1'b1;
          if (!probeEn) begin
            nextState        = ST_IDLE;
            strobe.clrPeriod = 1'b1;
            strobe.clrRamp   = 1'b1;
          end else if (status.periodDone) begin
            nextState        = ST_DISCH;
            strobe.clrPeriod = 1'b1;
            strobe.clrRamp   = 1'b1;
          end else if (vbusAboveProbe) begin
            strobe.capture  = 1'b1;
            strobe.setProbe = 1'b1;
            nextState       = ST_WAIT;
          end else if (status.rampSat) begin
            strobe.capture    = 1'b1;
            strobe.setTimeout = 1'b1;
            nextState         = ST_WAIT;
          end
        end
        ST_WAIT: begin
          strobe.clrPhase = 1'b1;
          strobe.clrRamp  = 1'b1;
          if (!probeEn) begin
            nextState        = ST_IDLE;
            strobe.clrPeriod = 1'b1;
          end else if (status.periodDone) begin
            nextState        = ST_DISCH;
            strobe.clrPeriod = 1'b1;
          end
        end
        ST_SENSE: begin
          strobe.clrPeriod = 1'b1;
          strobe.clrPhase  = 1'b1;
          strobe.clrRamp   = 1'b1;
          if (!senseEn || probeEn) nextState = ST_IDLE;
          else if (vbusAboveSense) strobe.setSense = 1'b1;
        end
        default: nextState = ST_IDLE;
      endcase
    end
  end

  assign dischargeOut = (state == ST_DISCH);
  assign chargeOut    = (state == ST_CHARGE);

endmodule

// File: rtl/adp_probe_datapath.sv
module adp_probe_datapath
  import adp_probe_pkg::*;
#(
  parameter int RAMP_W     = 11,
  parameter int DSCHG_BASE = 128,
  parameter int PERIOD0    = 24800,
  parameter int PERIOD1    = 49600,
  parameter int PERIOD2    = 72800,
  parameter int NUM_FLAGS  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              measuring,
  input  logic [1:0]        dischargeSel,
  input  logic [1:0]        resolSel,
  input  logic [1:0]        periodSel,
  input  adpStrobe_t        strobe,
  input  logic [NUM_FLAGS-1:0] clearVec,
  input  logic [NUM_FLAGS-1:0] maskVec,
  output adpStatus_t        status,
  output logic [RAMP_W-1:0] rampTime,
  output logic [NUM_FLAGS-1:0] flagVec,
  output logic              irq
);

  localparam int PMAX01 = (PERIOD0 > PERIOD1) ? PERIOD0 : PERIOD1;
  localparam int PMAX   = (PMAX01 > PERIOD2) ? PMAX01 : PERIOD2;
  localparam int PER_W  = $clog2(PMAX + 1);
  localparam int PH_W   = $clog2(DSCHG_BASE * 8 + 1);

  logic [PER_W-1:0]  periodCnt, periodLen;
  logic [PH_W-1:0]   phaseCnt, dischLen;
  logic [1:0]        preCnt;
  logic [RAMP_W-1:0] rampCnt;
  logic              incDue;
  logic [NUM_FLAGS-1:0] setVec;

  always_comb begin
    unique case (periodSel)
      2'b01:   periodLen = PER_W'(PERIOD1);
      2'b10:   periodLen = PER_W'(PERIOD2);
      default: periodLen = PER_W'(PERIOD0);
    endcase
  end

  assign dischLen = PH_W'(DSCHG_BASE) << dischargeSel;
  assign incDue   = measuring && tick && (preCnt == resolSel);

  assign status.periodDone = tick && (periodCnt == periodLen - PER_W'(1));
  assign status.dischDone  = tick && (phaseCnt == dischLen - PH_W'(1));
  assign status.rampSat    = incDue && (rampCnt == {RAMP_W{1'b1}});

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                periodCnt <= '0;
    else if (strobe.clrPeriod) periodCnt <= '0;
    else if (tick)            periodCnt <= periodCnt + PER_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               phaseCnt <= '0;
    else if (strobe.clrPhase) phaseCnt <= '0;
    else if (tick)           phaseCnt <= phaseCnt + PH_W'(1);
  end

  // Prescaler and saturating ramp counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt  <= '0;
      rampCnt <= '0;
    end else if (strobe.clrRamp) begin
      preCnt  <= '0;
      rampCnt <= '0;
    end else if (measuring && tick) begin
      if (incDue) begin
        preCnt <= '0;
        if (rampCnt != {RAMP_W{1'b1}}) rampCnt <= rampCnt + RAMP_W'(1);
      end else begin
        preCnt <= preCnt + 2'd1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              rampTime <= '0;
    else if (strobe.capture) rampTime <= rampCnt;
  end

  assign setVec = {strobe.setTimeout, strobe.setSense, strobe.setProbe};

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) flagVec[i] <= 1'b0;
      else       flagVec[i] <= (flagVec[i] && !clearVec[i]) || setVec[i];
    end
  end

  assign irq = |(flagVec & maskVec);

endmodule

// File: rtl/adp_probe_timer.sv
module adp_probe_timer
  import adp_probe_pkg::*;
#(
  parameter int RAMP_W     = 11,
  parameter int DSCHG_BASE = 128,
  parameter int PERIOD0    = 24800,
  parameter int PERIOD1    = 49600,
  parameter int PERIOD2    = 72800
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              enable,
  input  logic              probeEn,
  input  logic              senseEn,
  input  logic              ctrlReset,
  input  logic [1:0]        dischargeSel,
  input  logic [1:0]        resolSel,
  input  logic [1:0]        periodSel,
  input  logic              vbusAboveProbe,
  input  logic              vbusAboveSense,
  input  logic              probeMask,
  input  logic              senseMask,
  input  logic              timeoutMask,
  input  logic              clearProbe,
  input  logic              clearSense,
  input  logic              clearTimeout,
  output logic              dischargeOut,
  output logic              chargeOut,
  output logic [RAMP_W-1:0] rampTime,
  output logic              probeFlag,
  output logic              senseFlag,
  output logic              timeoutFlag,
  output logic              irq
);

  localparam int NUM_FLAGS = 3;

  adpStrobe_t           strobe;
  adpStatus_t           status;
  logic [NUM_FLAGS-1:0] flagVec;

  adp_probe_ctrl u_ctrl (
    .clk            (clk),
    .rstN           (rstN),
    .enable         (enable),
    .probeEn        (probeEn),
    .senseEn        (senseEn),
    .ctrlReset      (ctrlReset),
    .vbusAboveProbe (vbusAboveProbe),
    .vbusAboveSense (vbusAboveSense),
    .status         (status),
    .strobe         (strobe),
    .dischargeOut   (dischargeOut),
    .chargeOut      (chargeOut)
  );

  adp_probe_datapath #(
    .RAMP_W     (RAMP_W),
    .DSCHG_BASE (DSCHG_BASE),
    .PERIOD0    (PERIOD0),
    .PERIOD1    (PERIOD1),
    .PERIOD2    (PERIOD2),
    .NUM_FLAGS  (NUM_FLAGS)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .tick         (tick),
    .measuring    (chargeOut),
    .dischargeSel (dischargeSel),
    .resolSel     (resolSel),
    .periodSel    (periodSel),
    .strobe       (strobe),
    .clearVec     ({clearTimeout, clearSense, clearProbe}),
    .maskVec      ({timeoutMask, senseMask, probeMask}),
    .status       (status),
    .rampTime     (rampTime),
    .flagVec      (flagVec),
    .irq          (irq)
  );

  assign probeFlag   = flagVec[0];
  assign senseFlag   = flagVec[1];
  assign timeoutFlag = flagVec[2];

endmodule

// File: rtl/adp_probe_checker.sv
module adp_probe_checker #(
  parameter int RAMP_W = 11
) (
  input logic              clk,
  input logic              rstN,
  input logic              enable,
  input logic              vbusAboveSense,
  input logic              probeMask,
  input logic              senseMask,
  input logic              timeoutMask,
  input logic              clearProbe,
  input logic              clearSense,
  input logic              clearTimeout,
  input logic              dischargeOut,
  input logic              chargeOut,
  input logic [RAMP_W-1:0] rampTime,
  input logic              probeFlag,
  input logic              senseFlag,
  input logic              timeoutFlag,
  input logic              irq
);

  AST_OFF_IS_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (!dischargeOut && !chargeOut)); // R2

  AST_TIMEOUT_CODE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(timeoutFlag) |-> (rampTime == {RAMP_W{1'b1}})); // R6

  AST_SENSE_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(senseFlag) |-> $past(vbusAboveSense)); // R8

  AST_PROBE_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    $fell(probeFlag) |-> $past(clearProbe)); // R9

  AST_SENSE_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    $fell(senseFlag) |-> $past(clearSense)); // R9

  AST_TIMEOUT_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    $fell(timeoutFlag) |-> $past(clearTimeout)); // R9

  AST_ALL_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    (!probeMask && !senseMask && !timeoutMask) |-> !irq); // R10

  AST_RAMP_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(rampTime) |-> $past(chargeOut)); // R11

endmodule

bind adp_probe_timer adp_probe_checker #(.RAMP_W(RAMP_W)) u_adp_probe_checker (
  .clk            (clk),
  .rstN           (rstN),
  .enable         (enable),
  .vbusAboveSense (vbusAboveSense),
  .probeMask      (probeMask),
  .senseMask      (senseMask),
  .timeoutMask    (timeoutMask),
  .clearProbe     (clearProbe),
  .clearSense     (clearSense),
  .clearTimeout   (clearTimeout),
  .dischargeOut   (dischargeOut),
  .chargeOut      (chargeOut),
  .rampTime       (rampTime),
  .probeFlag      (probeFlag),
  .senseFlag      (senseFlag),
  .timeoutFlag    (timeoutFlag),
  .irq            (irq)
);

// File: tb/test_adp_probe_timer.sv
`timescale 1ns/1ps
module test_adp_probe_timer;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tick = 1'b1;
  logic tickHalf = 1'b0;
  logic enable = 1'b0, probeEn = 1'b0, senseEn = 1'b0, ctrlReset = 1'b0;
  logic [1:0] dischargeSel = '0, resolSel = '0, periodSel = '0;
  logic vbusAboveProbe = 1'b0, vbusAboveSense = 1'b0;
  logic probeMask = 1'b0, senseMask = 1'b0, timeoutMask = 1'b0;
  logic clearProbe = 1'b0, clearSense = 1'b0, clearTimeout = 1'b0;
  logic dischargeOut, chargeOut, probeFlag, senseFlag, timeoutFlag, irq;
  logic [10:0] rampTime;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  always @(negedge clk) tick <= tickHalf ? ~tick : 1'b1;

  adp_probe_timer i_adp_probe_timer (
    .clk(clk), .rstN(rstN), .tick(tick), .enable(enable), .probeEn(probeEn),
    .senseEn(senseEn), .ctrlReset(ctrlReset), .dischargeSel(dischargeSel),
    .resolSel(resolSel), .periodSel(periodSel), .vbusAboveProbe(vbusAboveProbe),
    .vbusAboveSense(vbusAboveSense), .probeMask(probeMask), .senseMask(senseMask),
    .timeoutMask(timeoutMask), .clearProbe(clearProbe), .clearSense(clearSense),
    .clearTimeout(clearTimeout), .dischargeOut(dischargeOut), .chargeOut(chargeOut),
    .rampTime(rampTime), .probeFlag(probeFlag), .senseFlag(senseFlag),
    .timeoutFlag(timeoutFlag), .irq(irq)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic goIdle();
    @(negedge clk);
    enable = 1'b0; probeEn = 1'b0; senseEn = 1'b0; ctrlReset = 1'b0;
    vbusAboveProbe = 1'b0; vbusAboveSense = 1'b0;
    repeat (2) @(negedge clk);
    clearProbe = 1'b1; clearSense = 1'b1; clearTimeout = 1'b1;
    @(negedge clk);
    clearProbe = 1'b0; clearSense = 1'b0; clearTimeout = 1'b0;
  endtask

  task automatic waitDischarge();
    for (int i = 0; i < 100000 && !dischargeOut; i++) @(negedge clk);
  endtask

  task automatic waitCharge();
    for (int i = 0; i < 5000 && !chargeOut; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(!dischargeOut && !chargeOut && rampTime == 0 && !probeFlag &&
          !senseFlag && !timeoutFlag && !irq, "R1 reset outputs", int'(rampTime), 0);
  endtask

  task automatic t_discharge(input logic [1:0] sel, input bit half, input int lo, input int hi);
    int cnt;
    goIdle();
    dischargeSel = sel; tickHalf = half;
    enable = 1'b1; probeEn = 1'b1;
    waitDischarge();
    cnt = 0;
    while (dischargeOut && cnt < 5000) begin
      cnt++;
      @(negedge clk);
    end
    check(cnt >= lo && cnt <= hi, "R4 discharge length", cnt, lo);
    check(chargeOut == 1'b1, "R4 charge follows discharge", int'(chargeOut), 1);
    tickHalf = 1'b0;
    dischargeSel = 2'b00;
  endtask

  task automatic t_ramp(input logic [1:0] res, input int k);
    logic [10:0] held;
    goIdle();
    resolSel = res;
    enable = 1'b1; probeEn = 1'b1;
    waitCharge();
    repeat (k) @(negedge clk);
    vbusAboveProbe = 1'b1;
    @(negedge clk);
    vbusAboveProbe = 1'b0;
    check(int'(rampTime) == k / (int'(res) + 1), "R5 ramp capture", int'(rampTime), k / (int'(res) + 1));
    check(probeFlag && !chargeOut, "R5 probe flag and charge end", int'(probeFlag), 1);
    held = rampTime;
    repeat (20) @(negedge clk);
    check(rampTime == held, "R11 ramp held while waiting", int'(rampTime), int'(held));
    goIdle();
    check(rampTime == held, "R11 ramp held in idle", int'(rampTime), int'(held));
    resolSel = 2'b00;
  endtask

  task automatic t_timeout();
    int cnt;
    goIdle();
    resolSel = 2'b01; timeoutMask = 1'b0;
    enable = 1'b1; probeEn = 1'b1;
    waitCharge();
    cnt = 0;
    while (chargeOut && cnt < 10000) begin
      cnt++;
      @(negedge clk);
    end
    check(cnt == 4096, "R6 timeout charge length", cnt, 4096);
    check(rampTime == 11'h7FF, "R6 timeout ramp code", int'(rampTime), 2047);
    check(timeoutFlag && !probeFlag, "R6 timeout flag", int'(timeoutFlag), 1);
    check(!irq, "R10 masked timeout keeps irq low", int'(irq), 0);
    timeoutMask = 1'b1;
    #1;
    check(irq, "R10 unmasked timeout drives irq", int'(irq), 1);
    timeoutMask = 1'b0;
    resolSel = 2'b00;
  endtask

  task automatic t_period(input logic [1:0] sel, input int exp);
    int cnt;
    bit prev;
    goIdle();
    periodSel = sel;
    enable = 1'b1; probeEn = 1'b1;
    waitDischarge();
    cnt = 0; prev = 1'b1;
    for (int i = 0; i < 100000; i++) begin
      @(negedge clk);
      cnt++;
      if (!prev && dischargeOut) break;
      prev = dischargeOut;
    end
    check(cnt == exp, "R7 probe period", cnt, exp);
    periodSel = 2'b00;
  endtask

  task automatic t_gating();
    goIdle();
    enable = 1'b1; probeEn = 1'b1;
    waitDischarge();
    repeat (5) @(negedge clk);
    ctrlReset = 1'b1;
    @(negedge clk);
    check(!dischargeOut && !chargeOut, "R2 control reset forces idle", int'(dischargeOut), 0);
    ctrlReset = 1'b0; enable = 1'b0;
    vbusAboveProbe = 1'b1; vbusAboveSense = 1'b1;
    repeat (10) @(negedge clk);
    check(!dischargeOut && !chargeOut, "R2 disabled strobes low", int'(chargeOut), 0);
    check(!probeFlag && !senseFlag, "R8 comparators ignored when idle", int'(probeFlag), 0);
  endtask

  task automatic t_sense();
    goIdle();
    senseMask = 1'b1;
    enable = 1'b1; senseEn = 1'b1; vbusAboveSense = 1'b1;
    repeat (3) @(negedge clk);
    check(senseFlag && !dischargeOut, "R3 sense mode sets sense flag", int'(senseFlag), 1);
    check(irq, "R10 unmasked sense drives irq", int'(irq), 1);
    clearSense = 1'b1;
    @(negedge clk);
    clearSense = 1'b0;
    check(senseFlag, "R9 set wins over clear", int'(senseFlag), 1);
    vbusAboveSense = 1'b0;
    repeat (3) @(negedge clk);
    check(senseFlag, "R9 flag sticky after input drops", int'(senseFlag), 1);
    clearSense = 1'b1;
    @(negedge clk);
    clearSense = 1'b0;
    check(!senseFlag && !irq, "R9 write-one clear", int'(senseFlag), 0);
    senseMask = 1'b0;
  endtask

  task automatic t_priority();
    goIdle();
    enable = 1'b1; probeEn = 1'b1; senseEn = 1'b1; vbusAboveSense = 1'b1;
    repeat (3) @(negedge clk);
    check(dischargeOut, "R3 probe wins over sense", int'(dischargeOut), 1);
    check(!senseFlag, "R3 no sense flag in probe mode", int'(senseFlag), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_discharge(2'b00, 1'b0, 128, 128);
    t_discharge(2'b01, 1'b0, 256, 256);
    t_discharge(2'b11, 1'b0, 1024, 1024);
    t_discharge(2'b00, 1'b1, 255, 256);
    t_ramp(2'b00, 10);
    t_ramp(2'b10, 10);
    t_ramp(2'b11, 0);
    t_timeout();
    t_gating();
    t_sense();
    t_priority();
    t_period(2'b00, 24800);
    t_period(2'b11, 24800);
    t_period(2'b01, 49600);
    goIdle();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #950000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule